// File: doc/BRIEF.md
# Four-Lane SHA-256 Message Schedule Expander

This block turns one 512-bit message block into the full 64-word SHA-256 message schedule. It gives out four 32-bit schedule words on each accepted output transfer, lowest index in the lowest lane. The first four transfers carry the sixteen message words unchanged. The next twelve carry the expanded words 16 to 63.

Each expansion step keeps a sliding window of the sixteen most recent schedule words. It forms the three-term partial sum `W[t-16] + W[t-7] + σ0(W[t-15])` for every lane in parallel. The `σ1(W[t-2])` term is then added lane by lane. Lanes 0 and 1 take their `W[t-2]` from the window. Lanes 2 and 3 take it from the words that lanes 0 and 1 produce in the same step. After each expanded group is transferred, the window shifts by four words.

Both edges of the block use valid/ready. A block is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while the unit is idle, so any `in_valid` during an expansion is ignored. The output holds its words and flags for as long as `out_valid` is high and `out_ready` is low. A group moves on only on a cycle where both are high.

Top module: `sha2_sched4`

## Requirements
- R1: After reset, or while reset is asserted, `out_valid` is 0 and `in_ready` is 1. A reset in the middle of a block abandons that block.
- R2: On a cycle where `in_valid` and `in_ready` are both high, the block on `in_block` is captured. In the next cycle `out_valid` is 1 and `in_ready` is 0. Message word j is `in_block[32j+31:32j]`.
- R3: Output groups 0 to 3 carry message words 4g to 4g+3 unchanged. Schedule word 4g+i appears on `out_words[32i+31:32i]`.
- R4: Output groups 4 to 15 carry schedule words 4g to 4g+3, defined as follows. For t from 16 to 63, `W[t] = σ1(W[t-2]) + W[t-7] + σ0(W[t-15]) + W[t-16]`, with all additions mod 2^32. `σ0(x) = ROTR7(x) ^ ROTR18(x) ^ SHR3(x)`. `σ1(x) = ROTR17(x) ^ ROTR19(x) ^ SHR10(x)`.
- R5: In every expanded group, lanes 2 and 3 are correct. Each uses as its `W[t-2]` the lane-0 or lane-1 word of the same group.
- R6: `out_last` is 1 exactly while group 15 is presented. In the cycle after group 15 is transferred, `out_valid` is 0 and `in_ready` is 1.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_words` and `out_last` hold their values and `out_valid` stays 1.
- R8: `in_valid` and `in_block` have no effect while a block is in progress. The sixteen groups output still belong to the block that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A message block is offered |
| in_ready | output | 1 | Unit is idle and will take a block |
| in_block | input | 512 | Sixteen message words, word j in bits [32j+31:32j] |
| out_valid | output | 1 | A group of schedule words is presented |
| out_ready | input | 1 | Consumer takes the presented group |
| out_words | output | LANES*32 | Group of schedule words, lane i in bits [32i+31:32i] |
| out_last | output | 1 | Presented group is the final one of the block |

## Verification
A wrong window shift or a stale lane pick shows up as a wrong value on `out_words`. It first appears in group 4 and spreads into every later group through the recurrence. A cross-lane error in the `W[t-2]` chain affects only lanes 2 and 3 at first, so those lanes are compared on their own as well. A group counter that is off by one moves `out_last`, or changes when `in_ready` comes back after the final transfer. That shows within the sixteen transfers of one block. Stalls and extra start requests are mixed into the runs, so that a stall which lets the output change, or a restart in the middle of a block, shows as an unstable output or a wrong group.

// File: rtl/sha2_sched_pkg.sv
package sha2_sched_pkg;

  localparam int WORD_W      = 32;
  localparam int WIN_WORDS   = 16;
  localparam int SCHED_WORDS = 64;
  localparam int BLOCK_W     = WIN_WORDS * WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  // small sigma applied to the far word W[t-15]
  function automatic word_t sig_lo(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  // small sigma applied to the near word W[t-2]
  function automatic word_t sig_hi(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

endpackage

// File: rtl/sha2_sched_window.sv
module sha2_sched_window
  import sha2_sched_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                                clk,
  input  logic                                load,
  input  logic [WIN_WORDS-1:0][WORD_W-1:0]    load_words,
  input  logic                                shift,
  input  logic [LANES-1:0][WORD_W-1:0]        fresh,
  output logic [WIN_WORDS-1:0][WORD_W-1:0]    win
);

  localparam int KEEP = WIN_WORDS - LANES;

  logic [WIN_WORDS-1:0][WORD_W-1:0] win_q;

  always_ff @(posedge clk) begin
    if (load) begin
      win_q <= load_words;
    end else if (shift) begin
      for (int j = 0; j < KEEP; j++) begin
        win_q[j] <= win_q[j+LANES];
      end
      for (int k = 0; k < LANES; k++) begin
        win_q[KEEP+k] <= fresh[k];
      end
    end
  end

  assign win = win_q;

endmodule

// File: rtl/sha2_sched_psum.sv
module sha2_sched_psum
  import sha2_sched_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [WIN_WORDS-1:0][WORD_W-1:0] win,
  output logic [LANES-1:0][WORD_W-1:0]     psum
);

  // Window slot k holds W[t+k-16] for the group starting at t.
  localparam int OFS_FAR  = 1;   // W[t-15]
  localparam int OFS_MID  = 9;   // W[t-7]

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign psum[k] = win[k] + win[k+OFS_MID] + sig_lo(win[k+OFS_FAR]);
  end

endmodule

// File: rtl/sha2_sched_tail.sv
module sha2_sched_tail
  import sha2_sched_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [WIN_WORDS-1:0][WORD_W-1:0] win,
  input  logic [LANES-1:0][WORD_W-1:0]     psum,
  output logic [LANES-1:0][WORD_W-1:0]     fresh
);

  localparam int NEAR_DIST = 2;
  localparam int NEAR_BASE = WIN_WORDS - NEAR_DIST;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    word_t near_w;
    word_t nw;
    if (k < NEAR_DIST) begin : g_from_win
      assign near_w = win[NEAR_BASE+k];
    end else begin : g_from_lane
      assign near_w = g_lane[k-NEAR_DIST].nw;
    end
    assign nw       = psum[k] + sig_hi(near_w);
    assign fresh[k] = nw;
  end

endmodule

// File: rtl/sha2_sched4.sv
module sha2_sched4
  import sha2_sched_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [BLOCK_W-1:0]        in_block,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANES*WORD_W-1:0]   out_words,
  output logic                      out_last
);

  localparam int IN_GROUPS  = WIN_WORDS / LANES;
  localparam int ALL_GROUPS = SCHED_WORDS / LANES;
  localparam int GRP_W      = $clog2(ALL_GROUPS);
  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(ALL_GROUPS - 1);

  logic             busy_q;
  logic [GRP_W-1:0] grp_q;
  logic             take_in;
  logic             take_out;
  logic             expanding;

  logic [WIN_WORDS-1:0][WORD_W-1:0] load_words;
  logic [WIN_WORDS-1:0][WORD_W-1:0] win;
  logic [LANES-1:0][WORD_W-1:0]     psum;
  logic [LANES-1:0][WORD_W-1:0]     fresh;
  logic [LANES-1:0][WORD_W-1:0]     pick;

  assign in_ready  = !busy_q;
  assign take_in   = in_valid && !busy_q;
  assign take_out  = busy_q && out_ready;
  assign expanding = (int'(grp_q) >= IN_GROUPS);

  for (genvar j = 0; j < WIN_WORDS; j++) begin : g_unpack
    assign load_words[j] = in_block[j*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      grp_q  <= '0;
    end else if (take_in) begin
      busy_q <= 1'b1;
      grp_q  <= '0;
    end else if (take_out) begin
      grp_q <= grp_q + 1'b1;
      if (grp_q == LAST_GRP) begin
        busy_q <= 1'b0;
      end
    end
  end

  sha2_sched_window #(.LANES(LANES)) u_window (
    .clk        (clk),
    .load       (take_in),
    .load_words (load_words),
    .shift      (take_out && expanding),
    .fresh      (fresh),
    .win        (win)
  );

  sha2_sched_psum #(.LANES(LANES)) u_psum (
    .win  (win),
    .psum (psum)
  );

  sha2_sched_tail #(.LANES(LANES)) u_tail (
    .win   (win),
    .psum  (psum),
    .fresh (fresh)
  );

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      if (expanding) begin
        pick[k] = fresh[k];
      end else begin
        pick[k] = win[(int'(grp_q) * LANES + k) % WIN_WORDS];
      end
    end
  end

  assign out_valid = busy_q;
  assign out_words = pick;
  assign out_last  = busy_q && (grp_q == LAST_GRP);

endmodule

// File: rtl/sha2_sched4_chk.sv
module sha2_sched4_chk
  import sha2_sched_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [BLOCK_W-1:0]      in_block,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANES*WORD_W-1:0] out_words,
  input logic                    out_last
);

  localparam int ALL_GROUPS = SCHED_WORDS / LANES;
  localparam int GRP_W      = $clog2(ALL_GROUPS);

  logic [GRP_W-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (in_valid && in_ready) begin
      seen_q <= '0;
    end else if (out_valid && out_ready) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && !in_ready)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_words) && $stable(out_last))); // R7

  AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (seen_q == GRP_W'(ALL_GROUPS - 1))); // R6

  AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!out_valid && in_ready)); // R6

  AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_ready && out_last)) |=> out_valid); // R8

endmodule

bind sha2_sched4 sha2_sched4_chk #(.LANES(LANES)) chk_i (.*);

// File: tb/sha2_sched4_tb_top.sv
`timescale 1ns/1ps
module sha2_sched4_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [511:0] in_block = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_words;
  logic         out_last;

  int errors = 0;
  int checks = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  sha2_sched4 dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .out_valid(out_valid), .out_ready(out_ready),
    .out_words(out_words), .out_last(out_last)
  );

  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  function automatic logic [31:0] s0f(input logic [31:0] x);
    return ror(x, 7) ^ ror(x, 18) ^ {3'b000, x[31:3]};
  endfunction

  function automatic logic [31:0] s1f(input logic [31:0] x);
    return ror(x, 17) ^ ror(x, 19) ^ {10'b0, x[31:10]};
  endfunction

  logic [31:0] ref_w [64];

  task automatic build_ref(input logic [511:0] blk);
    for (int t = 0; t < 64; t++) begin
      if (t < 16) ref_w[t] = blk[32*t +: 32];
      else ref_w[t] = s1f(ref_w[t-2]) + ref_w[t-7] + s0f(ref_w[t-15]) + ref_w[t-16];
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset idle",
        {126'b0, out_valid, in_ready}, 128'h1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // stall: 0 none, 1 light, 2 heavy; noise: offer a foreign block mid-run
  task automatic run_block(input logic [511:0] blk, input int stall, input bit noise,
                           input string tag);
    logic [127:0] exp;
    logic [127:0] prev_w;
    logic         prev_l;
    bit           have_prev;
    int           g;
    int           guard;
    build_ref(blk);
    chk(in_ready == 1'b1, {"R1 ready before ", tag}, {127'b0, in_ready}, 128'h1);
    in_valid = 1'b1; in_block = blk; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1 && in_ready == 1'b0, {"R2 accept ", tag},
        {126'b0, out_valid, in_ready}, 128'h2);
    g = 0; guard = 0; have_prev = 0;
    while (g < 16 && guard < 2000) begin
      guard++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (stall)
        0: out_ready = 1'b1;
        1: out_ready = lfsr[0] | lfsr[3];
        default: out_ready = lfsr[0] & lfsr[5];
      endcase
      if (noise && g < 15) begin
        in_valid = 1'b1; in_block = ~blk;
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (!out_valid) begin
        chk(1'b0, {"R8 valid dropped mid-block ", tag}, 128'h0, 128'h1);
        g = 16;
      end else begin
        if (have_prev) begin
          chk(out_words == prev_w && out_last == prev_l, {"R7 hold under stall ", tag},
              out_words, prev_w);
        end
        if (out_ready) begin
          exp = {ref_w[4*g+3], ref_w[4*g+2], ref_w[4*g+1], ref_w[4*g]};
          if (g < 4) chk(out_words == exp, {"R3 message group ", tag}, out_words, exp);
          else begin
            chk(out_words == exp, {noise ? "R8 " : "", "R4 expanded group ", tag},
                out_words, exp);
            chk(out_words[127:64] == exp[127:64], {"R5 upper lanes ", tag},
                {64'b0, out_words[127:64]}, {64'b0, exp[127:64]});
          end
          chk(out_last == (g == 15), {"R6 last flag ", tag},
              {127'b0, out_last}, {127'b0, g == 15});
          have_prev = 0;
          g++;
        end else begin
          have_prev = 1; prev_w = out_words; prev_l = out_last;
        end
      end
      @(negedge clk);
    end
    in_valid = 1'b0; out_ready = 1'b0;
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, {"R6 release ", tag},
        {126'b0, out_valid, in_ready}, 128'h1);
    @(negedge clk);
  endtask

  task automatic t_reset_mid();
    logic [511:0] blk;
    for (int j = 0; j < 16; j++) blk[32*j +: 32] = 32'h1000_0000 + j;
    in_valid = 1'b1; in_block = blk; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; out_ready = 1'b0;
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 mid-block reset",
        {126'b0, out_valid, in_ready}, 128'h1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [511:0] b;
    do_reset();
    for (int j = 0; j < 16; j++) b[32*j +: 32] = j;
    run_block(b, 0, 0, "incrementing");
    run_block('0, 0, 0, "zeros");
    run_block({512{1'b1}}, 1, 0, "ones light stall");
    b = '0; b[31:0] = 32'h61626380; b[511:480] = 32'h00000018;
    run_block(b, 2, 0, "short msg heavy stall");
    for (int j = 0; j < 16; j++) b[32*j +: 32] = 32'h9E3779B9 * (j + 1);
    run_block(b, 1, 1, "golden with foreign start");
    t_reset_mid();
    run_block(b, 0, 1, "after reset");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule